// File: doc/BRIEF.md
# Variable-Length Instruction Decoder

This block is a purely combinational decoder. It sits between instruction fetch and the execute stage of a small variable-length processor. Fetch supplies the first three bytes of the instruction buffer. The decoder returns four things:

- the opcode and register fields;
- the total length of the instruction in bytes, which fetch uses to advance the program counter;
- the control word that steers the register file ports, the operand multiplexer and the result selector;
- one-hot category flags for the control-flow forms.

The length follows from the upper opcode nibble alone. It is one of 2, 3, 6, 7 or 10 bytes. Three upper-nibble codes are reserved. When one of them arrives, the decoder raises an illegal flag and holds every enable and category output at zero. The block has no state, no clock and no reset. The "state" that the rest of the pipeline sees is the decoded class of the current instruction.

Top module: `vld_decoder`

## Requirements
- R1: The major code is `op_b0[7:4]` and the minor code is `op_b0[3:0]`. The destination register is `op_b1[7:4]`, the source register is `op_b1[3:0]`, the index register is `op_b2[7:4]` and the shift amount is `op_b2[3:0]`.
- R2: The length `ins_len` by major code is:
  - 0x0, 0x1, 0x2, 0x3 and 0x8 give 2;
  - 0x9 gives 3;
  - 0x4, 0x5, 0x6, 0x7 and 0xA give 6;
  - 0xB gives 7;
  - 0xF gives 10.
- R3: For majors 0x3 and 0x7, minor bit 3 at 0 raises `is_load` and minor bit 3 at 1 raises `is_store`. The two are never high together. Neither is raised for any other major.
- R4: Major 0x0 with minor 0x0 raises `is_stop`, and with minor 0x1 raises `is_return`. Every other minor under major 0x0 raises no flag and no enable.
- R5: Major 0x4 with minor 0xE raises `is_call`. Major 0x4 with minor 0xF raises `is_jump`. Every other minor of major 0x4, and every minor of major 0xF, raises `is_cond`. At most one control-flow flag is ever high.
- R6: Port A (`rd_a_reg`) reads the index register for majors 0x8 to 0xB and the destination register otherwise. Port B (`rd_b_reg`) always reads the source register.
- R7: `reg_we` is high for majors 0x1, 0x2, 0x5, 0x6 and 0x8 to 0xB, for loads, and for calls. It is low for everything else.
- R8: `use_imm` is high exactly for majors 0x5, 0x6 and 0xF.
- R9: `res_src` encodes the result source as follows: 0 none, 1 address generator, 2 ALU, 3 multiplier, 4 shifter, 5 direct move, 6 link value.
  - Leaq forms and memory moves select 1.
  - Majors 0x2 and 0x6 select 5.
  - Calls select 6.
  - Conditional forms select 2.
  - Arithmetic (0x1 and 0x5) selects 3 for minors 0xC/0xD, 4 for minors 0x8/0x9/0xA, and 2 otherwise.
- R10: For address-generator forms (majors 0x3, 0x7 and 0x8 to 0xB), `agen_use_s`, `agen_use_z` and `agen_use_d` equal minor bits 0, 1 and 2. For every other major they are 0.
- R11: `mul_signed` is high only for arithmetic minor 0xD. `shift_left` is high only for arithmetic minor 0xA. `shift_arith` is high for arithmetic minors 0x9 and 0xA.
- R12: Majors 0xC, 0xD and 0xE raise `illegal`. They give `ins_len` 0, `res_src` 0, and every enable, category and operand-select output at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_b0 | input | 8 | Instruction byte 0 (major and minor code) |
| op_b1 | input | 8 | Instruction byte 1 (destination and source register) |
| op_b2 | input | 8 | Instruction byte 2 (index register and shift amount) |
| major | output | 4 | Major opcode |
| minor | output | 4 | Minor opcode |
| reg_dst | output | 4 | Destination register specifier |
| reg_src | output | 4 | Source register specifier |
| reg_idx | output | 4 | Index register specifier |
| shamt | output | 4 | Shift amount field |
| rd_a_reg | output | 4 | Register read port A address |
| rd_b_reg | output | 4 | Register read port B address |
| ins_len | output | 4 | Instruction length in bytes, 0 if illegal |
| illegal | output | 1 | Reserved major code seen |
| reg_we | output | 1 | Register write enable |
| is_load | output | 1 | Memory read into register |
| is_store | output | 1 | Memory write from register |
| is_cond | output | 1 | Conditional control flow |
| use_imm | output | 1 | Immediate replaces port B operand |
| res_src | output | 3 | Result source select |
| agen_use_s | output | 1 | Address generator adds source register |
| agen_use_z | output | 1 | Address generator adds scaled index |
| agen_use_d | output | 1 | Address generator adds displacement |
| mul_signed | output | 1 | Multiplier works on signed operands |
| shift_left | output | 1 | Shifter direction is left |
| shift_arith | output | 1 | Shifter treats operand as signed |
| is_call | output | 1 | Call |
| is_jump | output | 1 | Unconditional jump |
| is_return | output | 1 | Return |
| is_stop | output | 1 | Stop |

## Verification
The embedded assertions check structural invariants on every evaluation:
- a legal length is always one of the five sizes, and a reserved code always yields zero;
- load and store exclude each other;
- the control-flow flags stay one-hot or idle;
- a call always writes a register;
- a reserved code leaves every enable low.

Only the bench's scenarios can show that each specific opcode selects the right length, result source and enables, and that the fields come from the right nibbles. It does this through a vector table and sweeps over every major code and every reserved minor.

// File: rtl/vld_pkg.sv
package vld_pkg;

    localparam int NIB_W = 4;
    localparam int SRC_W = 3;

    typedef enum logic [3:0] {
        MJ_SYS   = 4'h0,
        MJ_ALU_R = 4'h1,
        MJ_MOV_R = 4'h2,
        MJ_MEM_R = 4'h3,
        MJ_FLOW  = 4'h4,
        MJ_ALU_I = 4'h5,
        MJ_MOV_I = 4'h6,
        MJ_MEM_I = 4'h7,
        MJ_LEA2  = 4'h8,
        MJ_LEA3  = 4'h9,
        MJ_LEA6  = 4'hA,
        MJ_LEA7  = 4'hB,
        MJ_RSV_C = 4'hC,
        MJ_RSV_D = 4'hD,
        MJ_RSV_E = 4'hE,
        MJ_CBR   = 4'hF
    } major_e;

    typedef enum logic [SRC_W-1:0] {
        SRC_NONE   = 3'd0,
        SRC_AGEN   = 3'd1,
        SRC_ALU    = 3'd2,
        SRC_MUL    = 3'd3,
        SRC_SHIFT  = 3'd4,
        SRC_DIRECT = 3'd5,
        SRC_LINK   = 3'd6
    } res_src_e;

    localparam logic [NIB_W-1:0] MN_STOP = 4'h0;
    localparam logic [NIB_W-1:0] MN_RET  = 4'h1;
    localparam logic [NIB_W-1:0] MN_SHR  = 4'h8;
    localparam logic [NIB_W-1:0] MN_SAR  = 4'h9;
    localparam logic [NIB_W-1:0] MN_SAL  = 4'hA;
    localparam logic [NIB_W-1:0] MN_MUL  = 4'hC;
    localparam logic [NIB_W-1:0] MN_IMUL = 4'hD;
    localparam logic [NIB_W-1:0] MN_CALL = 4'hE;
    localparam logic [NIB_W-1:0] MN_JMP  = 4'hF;

    typedef struct packed {
        logic     reg_we;
        logic     load;
        logic     store;
        logic     cond;
        logic     use_imm;
        logic     call;
        logic     jump;
        logic     ret;
        logic     stop;
        res_src_e src;
        logic     agen_s;
        logic     agen_z;
        logic     agen_d;
        logic     mul_signed;
        logic     shift_left;
        logic     shift_arith;
    } ctrl_t;

endpackage

// File: rtl/vld_fields.sv
module vld_fields #(
    parameter int BYTE_W = 8,
    parameter int NIB_W  = 4
) (
    input  logic [BYTE_W-1:0] b0,
    input  logic [BYTE_W-1:0] b1,
    input  logic [BYTE_W-1:0] b2,
    output logic [NIB_W-1:0]  f_major,
    output logic [NIB_W-1:0]  f_minor,
    output logic [NIB_W-1:0]  f_rd,
    output logic [NIB_W-1:0]  f_rs,
    output logic [NIB_W-1:0]  f_rz,
    output logic [NIB_W-1:0]  f_shamt
);
    localparam int HI_TOP = BYTE_W - 1;
    localparam int HI_BOT = BYTE_W - NIB_W;
    localparam int LO_TOP = NIB_W - 1;

    // Upper nibble of each byte carries the first field, lower nibble the second
    always_comb begin
        f_major = b0[HI_TOP:HI_BOT];
        f_minor = b0[LO_TOP:0];
        f_rd    = b1[HI_TOP:HI_BOT];
        f_rs    = b1[LO_TOP:0];
        f_rz    = b2[HI_TOP:HI_BOT];
        f_shamt = b2[LO_TOP:0];
    end
endmodule

// File: rtl/vld_length.sv
module vld_length
    import vld_pkg::*;
#(
    parameter int LEN_W = 4
) (
    input  logic [NIB_W-1:0] mj,
    output logic [LEN_W-1:0] len,
    output logic             rsv
);
    localparam logic [LEN_W-1:0] LEN_SHORT = LEN_W'(2);
    localparam logic [LEN_W-1:0] LEN_SCALE = LEN_W'(3);
    localparam logic [LEN_W-1:0] LEN_WIDE  = LEN_W'(6);
    localparam logic [LEN_W-1:0] LEN_DISP  = LEN_W'(7);
    localparam logic [LEN_W-1:0] LEN_LONG  = LEN_W'(10);

    always_comb begin
        len = '0;
        rsv = 1'b0;
        unique case (major_e'(mj))
            MJ_SYS, MJ_ALU_R, MJ_MOV_R, MJ_MEM_R, MJ_LEA2:
                len = LEN_SHORT;
            MJ_LEA3:
                len = LEN_SCALE;
            MJ_FLOW, MJ_ALU_I, MJ_MOV_I, MJ_MEM_I, MJ_LEA6:
                len = LEN_WIDE;
            MJ_LEA7:
                len = LEN_DISP;
            MJ_CBR:
                len = LEN_LONG;
            MJ_RSV_C, MJ_RSV_D, MJ_RSV_E:
                rsv = 1'b1;
        endcase
    end

    // R2: only the five legal sizes, and zero exactly on reserved codes
    always_comb begin
        if (rsv) begin
            a_r2_len_zero_rsv: assert (len == '0)
                else $error("reserved code with nonzero length");
        end else begin
            a_r2_len_legal: assert (len == LEN_SHORT || len == LEN_SCALE ||
                                    len == LEN_WIDE  || len == LEN_DISP ||
                                    len == LEN_LONG)
                else $error("illegal length value");
        end
    end
endmodule

// File: rtl/vld_ctrl.sv
module vld_ctrl
    import vld_pkg::*;
(
    input  logic [NIB_W-1:0] mj,
    input  logic [NIB_W-1:0] mn,
    input  logic             rsv,
    output ctrl_t            c,
    output logic             sel_idx
);
    logic arith_mul;
    logic arith_shift;

    always_comb begin
        arith_mul   = (mn == MN_MUL) || (mn == MN_IMUL);
        arith_shift = (mn == MN_SHR) || (mn == MN_SAR) || (mn == MN_SAL);
    end

    always_comb begin
        c       = '0;
        c.src   = SRC_NONE;
        sel_idx = 1'b0;
        if (!rsv) begin
            unique case (major_e'(mj))
                MJ_SYS: begin
                    c.stop = (mn == MN_STOP);
                    c.ret  = (mn == MN_RET);
                end
                MJ_ALU_R, MJ_ALU_I: begin
                    c.reg_we  = 1'b1;
                    c.use_imm = (major_e'(mj) == MJ_ALU_I);
                    if (arith_mul) begin
                        c.src        = SRC_MUL;
                        c.mul_signed = (mn == MN_IMUL);
                    end else if (arith_shift) begin
                        c.src         = SRC_SHIFT;
                        c.shift_left  = (mn == MN_SAL);
                        c.shift_arith = (mn == MN_SAR) || (mn == MN_SAL);
                    end else begin
                        c.src = SRC_ALU;
                    end
                end
                MJ_MOV_R, MJ_MOV_I: begin
                    c.reg_we  = 1'b1;
                    c.src     = SRC_DIRECT;
                    c.use_imm = (major_e'(mj) == MJ_MOV_I);
                end
                MJ_MEM_R, MJ_MEM_I: begin
                    c.src    = SRC_AGEN;
                    c.load   = ~mn[3];
                    c.store  = mn[3];
                    c.reg_we = ~mn[3];
                    c.agen_s = mn[0];
                    c.agen_z = mn[1];
                    c.agen_d = mn[2];
                end
                MJ_FLOW: begin
                    if (mn == MN_CALL) begin
                        c.call   = 1'b1;
                        c.reg_we = 1'b1;
                        c.src    = SRC_LINK;
                    end else if (mn == MN_JMP) begin
                        c.jump = 1'b1;
                    end else begin
                        c.cond = 1'b1;
                        c.src  = SRC_ALU;
                    end
                end
                MJ_LEA2, MJ_LEA3, MJ_LEA6, MJ_LEA7: begin
                    sel_idx  = 1'b1;
                    c.reg_we = 1'b1;
                    c.src    = SRC_AGEN;
                    c.agen_s = mn[0];
                    c.agen_z = mn[1];
                    c.agen_d = mn[2];
                end
                MJ_CBR: begin
                    c.cond    = 1'b1;
                    c.use_imm = 1'b1;
                    c.src     = SRC_ALU;
                end
                MJ_RSV_C, MJ_RSV_D, MJ_RSV_E: begin
                    c.src = SRC_NONE;
                end
            endcase
        end
    end

    // Invariants over the control word, with rsv driven by the length decoder
    always_comb begin
        a_r3_ldst_exclusive: assert (!(c.load && c.store))
            else $error("load and store together");
        a_r5_flow_onehot: assert ($onehot0({c.call, c.jump, c.cond, c.ret, c.stop}))
            else $error("control-flow flags overlap");
        if (c.call) begin
            a_r7_call_writes: assert (c.reg_we)
                else $error("call without register write");
        end
        if (rsv) begin
            a_r12_rsv_quiet: assert (!c.reg_we && !c.load && !c.store && !c.cond &&
                                     !c.use_imm && c.src == SRC_NONE && !sel_idx)
                else $error("reserved code left an enable high");
        end
    end
endmodule

// File: rtl/vld_decoder.sv
module vld_decoder
    import vld_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int LEN_W  = 4
) (
    input  logic [BYTE_W-1:0] op_b0,
    input  logic [BYTE_W-1:0] op_b1,
    input  logic [BYTE_W-1:0] op_b2,
    output logic [3:0]        major,
    output logic [3:0]        minor,
    output logic [3:0]        reg_dst,
    output logic [3:0]        reg_src,
    output logic [3:0]        reg_idx,
    output logic [3:0]        shamt,
    output logic [3:0]        rd_a_reg,
    output logic [3:0]        rd_b_reg,
    output logic [LEN_W-1:0]  ins_len,
    output logic              illegal,
    output logic              reg_we,
    output logic              is_load,
    output logic              is_store,
    output logic              is_cond,
    output logic              use_imm,
    output logic [2:0]        res_src,
    output logic              agen_use_s,
    output logic              agen_use_z,
    output logic              agen_use_d,
    output logic              mul_signed,
    output logic              shift_left,
    output logic              shift_arith,
    output logic              is_call,
    output logic              is_jump,
    output logic              is_return,
    output logic              is_stop
);
    logic [NIB_W-1:0] f_major, f_minor, f_rd, f_rs, f_rz, f_shamt;
    logic             rsv;
    logic             sel_idx;
    ctrl_t            cw;

    vld_fields #(.BYTE_W(BYTE_W), .NIB_W(NIB_W)) u_fields (
        .b0(op_b0), .b1(op_b1), .b2(op_b2),
        .f_major(f_major), .f_minor(f_minor),
        .f_rd(f_rd), .f_rs(f_rs), .f_rz(f_rz), .f_shamt(f_shamt)
    );

    vld_length #(.LEN_W(LEN_W)) u_length (
        .mj(f_major), .len(ins_len), .rsv(rsv)
    );

    vld_ctrl u_ctrl (
        .mj(f_major), .mn(f_minor), .rsv(rsv), .c(cw), .sel_idx(sel_idx)
    );

    always_comb begin
        major       = f_major;
        minor       = f_minor;
        reg_dst     = f_rd;
        reg_src     = f_rs;
        reg_idx     = f_rz;
        shamt       = f_shamt;
        rd_a_reg    = sel_idx ? f_rz : f_rd;
        rd_b_reg    = f_rs;
        illegal     = rsv;
        reg_we      = cw.reg_we;
        is_load     = cw.load;
        is_store    = cw.store;
        is_cond     = cw.cond;
        use_imm     = cw.use_imm;
        res_src     = cw.src;
        agen_use_s  = cw.agen_s;
        agen_use_z  = cw.agen_z;
        agen_use_d  = cw.agen_d;
        mul_signed  = cw.mul_signed;
        shift_left  = cw.shift_left;
        shift_arith = cw.shift_arith;
        is_call     = cw.call;
        is_jump     = cw.jump;
        is_return   = cw.ret;
        is_stop     = cw.stop;
    end
endmodule

// File: tb/tb_vld_decoder.sv
module tb_vld_decoder;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic [7:0] op_b0 = '0, op_b1 = '0, op_b2 = '0;
    logic [3:0] major, minor, reg_dst, reg_src, reg_idx, shamt, rd_a_reg, rd_b_reg, ins_len;
    logic illegal, reg_we, is_load, is_store, is_cond, use_imm;
    logic [2:0] res_src;
    logic agen_use_s, agen_use_z, agen_use_d, mul_signed, shift_left, shift_arith;
    logic is_call, is_jump, is_return, is_stop;

    vld_decoder dut (.*);

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    // byte0 | length | result source | we ld st cond imm call jmp ret stop ill
    localparam logic [24:0] VEC [22] = '{
        {8'h00, 4'd2,  3'd0, 10'b0000000010},
        {8'h01, 4'd2,  3'd0, 10'b0000000100},
        {8'h05, 4'd2,  3'd0, 10'b0000000000},
        {8'h10, 4'd2,  3'd2, 10'b1000000000},
        {8'h1C, 4'd2,  3'd3, 10'b1000000000},
        {8'h59, 4'd6,  3'd4, 10'b1000100000},
        {8'h20, 4'd2,  3'd5, 10'b1000000000},
        {8'h60, 4'd6,  3'd5, 10'b1000100000},
        {8'h31, 4'd2,  3'd1, 10'b1100000000},
        {8'h38, 4'd2,  3'd1, 10'b0010000000},
        {8'h7F, 4'd6,  3'd1, 10'b0010000000},
        {8'h4E, 4'd6,  3'd6, 10'b1000010000},
        {8'h4F, 4'd6,  3'd0, 10'b0000001000},
        {8'h42, 4'd6,  3'd2, 10'b0001000000},
        {8'hF3, 4'd10, 3'd2, 10'b0001100000},
        {8'hFE, 4'd10, 3'd2, 10'b0001100000},
        {8'h87, 4'd2,  3'd1, 10'b1000000000},
        {8'h93, 4'd3,  3'd1, 10'b1000000000},
        {8'hA0, 4'd6,  3'd1, 10'b1000000000},
        {8'hB4, 4'd7,  3'd1, 10'b1000000000},
        {8'hC5, 4'd0,  3'd0, 10'b0000000001},
        {8'hE0, 4'd0,  3'd0, 10'b0000000001}
    };

    function automatic logic [3:0] spec_len(input logic [3:0] m);
        case (m)
            4'h0, 4'h1, 4'h2, 4'h3, 4'h8: return 4'd2;
            4'h9:                         return 4'd3;
            4'h4, 4'h5, 4'h6, 4'h7, 4'hA: return 4'd6;
            4'hB:                         return 4'd7;
            4'hF:                         return 4'd10;
            default:                      return 4'd0;
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic apply(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
        @(posedge clk);
        op_b0 = a; op_b1 = b; op_b2 = c;
        @(negedge clk);
    endtask

    function automatic logic [9:0] flags();
        return {reg_we, is_load, is_store, is_cond, use_imm,
                is_call, is_jump, is_return, is_stop, illegal};
    endfunction

    initial begin
        while (cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        // Idle state: all-zero buffer decodes as stop (R4)
        @(negedge clk);
        check("R4", "idle stop", is_stop, 1);
        check("R2", "idle len", ins_len, 2);

        // Vector table: R2 R3 R4 R5 R7 R8 R9 R12
        for (int i = 0; i < 22; i++) begin
            apply(VEC[i][24:17], 8'h00, 8'h00);
            check("R2", $sformatf("len op %0h", VEC[i][24:17]), ins_len, VEC[i][16:13]);
            check("R9", $sformatf("src op %0h", VEC[i][24:17]), res_src, VEC[i][12:10]);
            check("R3 R4 R5 R7 R8 R12", $sformatf("flags op %0h", VEC[i][24:17]),
                  flags(), VEC[i][9:0]);
        end

        // R1 field positions; R6 port A uses destination for non-leaq
        apply(8'h5A, 8'h3C, 8'h9E);
        check("R1", "major", major, 4'h5);
        check("R1", "minor", minor, 4'hA);
        check("R1", "dst", reg_dst, 4'h3);
        check("R1", "src", reg_src, 4'hC);
        check("R1", "idx", reg_idx, 4'h9);
        check("R1", "shamt", shamt, 4'hE);
        check("R6", "port A non-leaq", rd_a_reg, 4'h3);
        check("R6", "port B", rd_b_reg, 4'hC);
        apply(8'h9A, 8'h3C, 8'h9E);
        check("R6", "port A leaq", rd_a_reg, 4'h9);
        check("R6", "port B leaq", rd_b_reg, 4'hC);

        // R10 agen enables
        apply(8'h35, 8'h00, 8'h00);
        check("R10", "agen load 5", {agen_use_s, agen_use_z, agen_use_d}, 3'b101);
        apply(8'hA6, 8'h00, 8'h00);
        check("R10", "agen leaq 6", {agen_use_s, agen_use_z, agen_use_d}, 3'b011);
        apply(8'h17, 8'h00, 8'h00);
        check("R10", "agen arith", {agen_use_s, agen_use_z, agen_use_d}, 3'b000);
        apply(8'h47, 8'h00, 8'h00);
        check("R10", "agen flow", {agen_use_s, agen_use_z, agen_use_d}, 3'b000);

        // R11 multiplier and shifter controls
        apply(8'h1D, 8'h00, 8'h00);
        check("R11", "imul", {mul_signed, shift_left, shift_arith}, 3'b100);
        apply(8'h5C, 8'h00, 8'h00);
        check("R11", "mul", {mul_signed, shift_left, shift_arith}, 3'b000);
        apply(8'h18, 8'h00, 8'h00);
        check("R11", "shr", {mul_signed, shift_left, shift_arith}, 3'b000);
        apply(8'h19, 8'h00, 8'h00);
        check("R11", "sar", {mul_signed, shift_left, shift_arith}, 3'b001);
        apply(8'h1A, 8'h00, 8'h00);
        check("R11", "sal", {mul_signed, shift_left, shift_arith}, 3'b011);
        apply(8'h3D, 8'h00, 8'h00);
        check("R11", "mem minor D", {mul_signed, shift_left, shift_arith}, 3'b000);

        // R2 length sweep over every major
        for (int m = 0; m < 16; m++) begin
            apply({m[3:0], 4'h3}, 8'h00, 8'h00);
            check("R2", $sformatf("sweep major %0h", m), ins_len, spec_len(m[3:0]));
        end

        // R5 every minor of major F is conditional
        for (int n = 0; n < 16; n++) begin
            apply({4'hF, n[3:0]}, 8'h00, 8'h00);
            check("R5", $sformatf("cbr minor %0h", n),
                  {is_cond, is_call, is_jump}, 3'b100);
        end

        // R12 reserved majors with every minor: all zero
        for (int m = 12; m < 15; m++) begin
            for (int n = 0; n < 16; n++) begin
                apply({m[3:0], n[3:0]}, 8'hA5, 8'h5A);
                check("R12", $sformatf("rsv %0h%0h", m, n),
                      {illegal, ins_len, res_src, flags(), agen_use_s, agen_use_z,
                       agen_use_d, mul_signed, shift_left, shift_arith},
                      {1'b1, 4'd0, 3'd0, 10'b0000000001, 6'b0});
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule